// File: doc/BRIEF.md
# Modem Status Register with Loopback Reflection

This block produces the 8-bit modem status value of a serial port model from the modem control value that software programs. When the control value has its loopback bit set, the four control outputs are looped back onto the four status inputs. When loopback is off, the block reports a line that is always connected: carrier detect and data-set-ready are held high, and clear-to-send and ring indicator are held low. Physical modem pins and their synchronisers are not part of this block.

The block keeps four sticky change flags in the low nibble of the status value. Each control update compares the new status lines with the old ones and sets the matching flags. Flags that are already set stay set until the status value is read. A read strobe returns the current value and clears the flags on the same clock edge. A separate output reports whether any flag is set, so that interrupt priority logic can use it.

Top module: `modem_status_unit`

## Requirements
- R1: When an update strobe carries a control value with bit 4 (loopback) set, the status lines become CTS (bit 4) = control bit 1, DSR (bit 5) = control bit 0, RI (bit 6) = control bit 2 and DCD (bit 7) = control bit 3. Control bits 7:5 have no effect. The new lines are visible on the cycle after the strobe.
- R2: When an update strobe carries a control value with bit 4 clear, the status bits 7:4 become 4'b1010 (DCD=1, RI=0, DSR=1, CTS=0), whatever control bits 3:0 hold.
- R3: On an update, a change of CTS, DSR or DCD sets flag bit 0, 1 or 3 respectively.
- R4: Flag bit 2 is set only when RI goes from 1 to 0 on an update. A rise of RI, or RI staying the same, leaves it untouched.
- R5: Set flags stay set across later updates. The new flag nibble is the old flags ORed with the flags the update produces.
- R6: On a read strobe, the output value in that cycle is the value returned. On the next cycle bits 3:0 are zero and bits 7:4 are unchanged.
- R7: The pending output is high exactly when any of status bits 3:0 is set.
- R8: After reset the status value is 8'hA0 and the pending output is low.
- R9: When an update and a read occur in the same cycle, the read returns the value from before the update. Flags from before the update are cleared, and flags produced by the update remain set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| mcrValue | input | 8 | Modem control value, sampled when mcrWrite is high |
| mcrWrite | input | 1 | Update strobe for the control value |
| msrRead | input | 1 | Read strobe; clears the change flags after this cycle |
| msrValue | output | 8 | Current modem status value |
| deltaPending | output | 1 | High while any change flag is set |

## Verification
A control update and a status read can happen in the same clock cycle. This is the one case where the flag-clear path and the flag-set path compete for the same register. The bench drives both strobes in one cycle, samples the output before the edge and expects the pre-update value. After the edge it expects only the flags produced by that update. It does this twice: once where the update creates new flags, and once where it creates none, so that stale flags must disappear.

// File: rtl/msr_pkg.sv
package msr_pkg;
  // Control-value bit positions
  localparam int CtlDtrBit  = 0;
  localparam int CtlRtsBit  = 1;
  localparam int CtlOut1Bit = 2;
  localparam int CtlOut2Bit = 3;
  localparam int CtlLoopBit = 4;

  // Line indices inside the upper status nibble (status bit = index + LINE_CNT)
  localparam int LINE_CNT = 4;
  localparam int LnCts = 0;
  localparam int LnDsr = 1;
  localparam int LnRi  = 2;
  localparam int LnDcd = 3;

  // Lines reported when loopback is off: DCD and DSR high
  localparam logic [LINE_CNT-1:0] IDLE_LINES = 4'b1010;

  typedef struct packed {
    logic update;
    logic clearDelta;
    logic loopback;
  } msr_strobe_t;
endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic [CTL_W-1:0] mcrIn,
  input  logic             writeReq,
  input  logic             readReq,
  output msr_strobe_t      strobe
);
  always_comb begin
    strobe.update     = writeReq;
    strobe.clearDelta = readReq;
    strobe.loopback   = mcrIn[CtlLoopBit];
  end
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int CTL_W = 8,
  parameter int MSR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  msr_strobe_t      strobe,
  input  logic [CTL_W-1:0] mcrIn,
  output logic [MSR_W-1:0] msrOut,
  output logic             anyDelta
);
  localparam int LINES = MSR_W / 2;

  logic [LINES-1:0] lineState;
  logic [LINES-1:0] deltaFlags;
  logic [LINES-1:0] targetLines;
  logic [LINES-1:0] edgeHit;
  logic [LINES-1:0] deltaNext;

  always_comb begin
    if (strobe.loopback) begin
      targetLines        = '0;
      targetLines[LnCts] = mcrIn[CtlRtsBit];
      targetLines[LnDsr] = mcrIn[CtlDtrBit];
      targetLines[LnRi]  = mcrIn[CtlOut1Bit];
      targetLines[LnDcd] = mcrIn[CtlOut2Bit];
    end else begin
      targetLines = IDLE_LINES;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (i == LnRi) begin : g_trail
      assign edgeHit[i] = lineState[i] & ~targetLines[i];
    end else begin : g_any
      assign edgeHit[i] = lineState[i] ^ targetLines[i];
    end
  end

  always_comb begin
    deltaNext = strobe.clearDelta ? '0 : deltaFlags;
    if (strobe.update) deltaNext = deltaNext | edgeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineState  <= IDLE_LINES;
      deltaFlags <= '0;
    end else begin
      if (strobe.update) lineState <= targetLines;
      deltaFlags <= deltaNext;
    end
  end

  assign msrOut   = {lineState, deltaFlags};
  assign anyDelta = |deltaFlags;
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int CTL_W = 8,
  parameter int MSR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CTL_W-1:0] mcrValue,
  input  logic             mcrWrite,
  input  logic             msrRead,
  output logic [MSR_W-1:0] msrValue,
  output logic             deltaPending
);
  msr_strobe_t strobe;

  msr_ctrl #(.CTL_W(CTL_W)) i_ctrl (
    .mcrIn   (mcrValue),
    .writeReq(mcrWrite),
    .readReq (msrRead),
    .strobe  (strobe)
  );

  msr_datapath #(.CTL_W(CTL_W), .MSR_W(MSR_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mcrIn   (mcrValue),
    .msrOut  (msrValue),
    .anyDelta(deltaPending)
  );
endmodule

// File: rtl/modem_status_checker.sv
module modem_status_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] mcrValue,
  input logic       mcrWrite,
  input logic       msrRead,
  input logic [7:0] msrValue,
  input logic       deltaPending
);
  AST_PEND_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    deltaPending == (msrValue[3:0] != 4'd0)); // R7

  AST_FIXED_LINES: assert property (@(posedge clk) disable iff (!rstN)
    (mcrWrite && !mcrValue[4]) |=> (msrValue[7:4] == 4'b1010)); // R2

  AST_LOOP_CTS: assert property (@(posedge clk) disable iff (!rstN)
    (mcrWrite && mcrValue[4]) |=> (msrValue[4] == $past(mcrValue[1]))); // R1

  AST_LOOP_DCD: assert property (@(posedge clk) disable iff (!rstN)
    (mcrWrite && mcrValue[4]) |=> (msrValue[7] == $past(mcrValue[3]))); // R1

  AST_RI_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (mcrWrite && !msrValue[6] && !msrValue[2]) |=> !msrValue[2]); // R4

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (mcrWrite && !msrRead) |=>
      ((msrValue[3:0] & $past(msrValue[3:0])) == $past(msrValue[3:0]))); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (msrRead && !mcrWrite) |=> (msrValue[3:0] == 4'd0)); // R6

  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !mcrWrite |=> $stable(msrValue[7:4])); // R6
endmodule

bind modem_status_unit modem_status_checker i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .mcrValue    (mcrValue),
  .mcrWrite    (mcrWrite),
  .msrRead     (msrRead),
  .msrValue    (msrValue),
  .deltaPending(deltaPending)
);

// File: tb/test_modem_status_unit.sv
`timescale 1ns/1ps
module test_modem_status_unit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] mcrValue = '0;
  logic       mcrWrite = 1'b0;
  logic       msrRead = 1'b0;
  logic [7:0] msrValue;
  logic       deltaPending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_unit i_modem_status_unit (
    .clk(clk), .rstN(rstN), .mcrValue(mcrValue), .mcrWrite(mcrWrite),
    .msrRead(msrRead), .msrValue(msrValue), .deltaPending(deltaPending)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one update strobe; outputs are sampled on the following falling edge
  task automatic writeCtl(logic [7:0] v);
    mcrValue = v; mcrWrite = 1'b1;
    @(negedge clk);
    mcrWrite = 1'b0;
  endtask

  // Read strobe: value returned is what is on the output during the strobe cycle
  task automatic readStat(output logic [7:0] got);
    msrRead = 1'b1;
    got = msrValue;
    @(negedge clk);
    msrRead = 1'b0;
  endtask

  task automatic testReset();
    check("R8 reset value", msrValue, 8'hA0);
    check("R8 R7 reset pending", {7'd0, deltaPending}, 8'h00);
  endtask

  task automatic testNoLoop();
    writeCtl(8'h0F);
    check("R2 non-loopback lines", msrValue, 8'hA0);
    writeCtl(8'hEF);
    check("R2 upper control bits", msrValue, 8'hA0);
  endtask

  task automatic testEnterLoop();
    logic [7:0] got;
    writeCtl(8'h10);
    check("R3 DSR DCD change flags", msrValue, 8'h0A);
    check("R7 pending high", {7'd0, deltaPending}, 8'h01);
    readStat(got);
    check("R6 read returns value", got, 8'h0A);
    check("R6 flags cleared", msrValue, 8'h00);
    check("R7 pending low", {7'd0, deltaPending}, 8'h00);
  endtask

  task automatic testRiEdges();
    logic [7:0] got;
    writeCtl(8'h13);
    check("R1 R3 CTS DSR from RTS DTR", msrValue, 8'h33);
    readStat(got);
    check("R6 lines kept after read", msrValue, 8'h30);
    writeCtl(8'h14);
    check("R4 RI rise gives no flag", msrValue, 8'h43);
    readStat(got);
    writeCtl(8'h10);
    check("R4 RI fall sets flag", msrValue, 8'h04);
    readStat(got);
    check("R4 RI flag read", got, 8'h04);
    check("R6 cleared after RI", msrValue, 8'h00);
  endtask

  task automatic testSticky();
    logic [7:0] got;
    writeCtl(8'h12);
    check("R3 CTS flag", msrValue, 8'h11);
    writeCtl(8'h13);
    check("R5 CTS flag kept, DSR added", msrValue, 8'h33);
    readStat(got);
    check("R6 clear after sticky", msrValue, 8'h30);
  endtask

  task automatic testAllLoop();
    logic [7:0] got;
    writeCtl(8'h1F);
    check("R1 all lines looped", msrValue, 8'hF8);
    readStat(got);
    writeCtl(8'hFF);
    check("R1 bits 7:5 ignored", msrValue, 8'hF0);
  endtask

  task automatic testCollision();
    logic [7:0] got;
    mcrValue = 8'h00; mcrWrite = 1'b1; msrRead = 1'b1;
    got = msrValue;
    @(negedge clk);
    mcrWrite = 1'b0; msrRead = 1'b0;
    check("R9 read returns pre-update", got, 8'hF0);
    check("R9 new flags survive clear", msrValue, 8'hA5);
    mcrValue = 8'h00; mcrWrite = 1'b1; msrRead = 1'b1;
    got = msrValue;
    @(negedge clk);
    mcrWrite = 1'b0; msrRead = 1'b0;
    check("R9 read returns stale flags", got, 8'hA5);
    check("R9 stale flags cleared", msrValue, 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoLoop();
    testEnterLoop();
    testRiEdges();
    testSticky();
    testAllLoop();
    testCollision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule